// File: doc/BRIEF.md
# Timer DMA Burst Register Writer

This unit lets a DMA engine update a run of consecutive timer registers through one fixed buffer address. Software programs a configuration word with a start register index, a transfer count and a mask of the internal timer events that may launch a burst. When an enabled event pulses while the unit is idle, the unit raises a DMA request. Each DMA write to the buffer address is passed on to the timer register file at the current index, and the index then moves to the next 32-bit register.

A count of N gives N+1 transfers. Only one request is outstanding at any time. After each acknowledge the request drops for one cycle and is raised again while transfers remain. Events that arrive during a burst are dropped. If the next index would fall past the last implemented register, the burst stops and an error flag is raised. That flag clears when the next burst starts.

The bus port decodes only two byte offsets: the configuration word and the buffer. A buffer write that arrives while idle goes to the start index.

Top module: `tmr_burst_dma`

## Requirements
- R1: A bus write to the buffer offset (0x4C) forwards its data to the register file in the same cycle. During a burst it targets the current index. While idle it targets the configured start index. `rf_addr_o` is the byte address, index times 4.
- R2: A configured count N (configuration bits [12:8]) produces exactly N+1 requests and N+1 forwarded writes. A count of 0 gives one.
- R3: An event bit that is set in the configuration mask (bits [16+k] for event k), pulsing while idle, starts a burst. `busy_o` and `dma_req_o` are high at the following cycle. An event whose mask bit is clear has no effect.
- R4: At most one request is outstanding. After a cycle with `dma_req_o` and `dma_ack_i` both high, `dma_req_o` is low for exactly one cycle. It then returns high if transfers remain.
- R5: Within a burst, each acknowledged transfer advances the target by one register, so successive write addresses rise by 4 bytes, starting from the start index (configuration bits [4:0]) times 4.
- R6: Events arriving while a burst is in progress are ignored. They neither extend nor restart it.
- R7: `busy_o` is high from the cycle after the starting event until the clock edge that takes the final acknowledge, and low after it.
- R8: With 20 implemented registers (indices 0 to 19), no write is forwarded to an index above 19. A burst that would advance past index 19 ends after that write and sets `err_o`. A burst whose start index is above 19 sets `err_o` and raises no request. `err_o` clears when a later burst starts.
- R9: The start index and count are captured when a burst starts. A configuration write during a burst does not change that burst.
- R10: After reset the request, busy and error outputs are low and the configuration is zero, so no event is enabled.
- R11: A new enabled event after a burst has completed repeats the whole sequence from the start index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Internal timer event pulses |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | AW | Bus byte address |
| bus_wdata_i | input | DW | Bus write data |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge, asserted with the buffer write |
| rf_we_o | output | 1 | Register-file write enable |
| rf_addr_o | output | 7 | Register-file byte address |
| rf_wdata_o | output | DW | Register-file write data |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | Last burst ran past the final register |

## Verification
Bursts are run with several start indices, with counts of 0, 1, 2 and 3, and with acknowledge delays of zero and several cycles. Matching the logged write addresses and data shows whether the index steps by one register per acknowledge, and whether the transfer total is count+1. Events with a clear mask bit, and events fired in the middle of a burst, separate a correctly gated start from a spurious restart. Start indices near and beyond the last register, a configuration rewrite in the middle of a burst, and idle buffer writes show whether the error stop, the capture of the configuration and the idle steering each behave as specified.

// File: rtl/tmr_burst_pkg.sv
package tmr_burst_pkg;
  localparam int IDX_W     = 5;
  localparam int CNT_W     = 5;
  localparam int START_LSB = 0;
  localparam int CNT_LSB   = 8;
  localparam int MASK_LSB  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] start;
  } burst_cfg_t;
endpackage

// File: rtl/tbd_cfg_reg.sv
module tbd_cfg_reg
  import tmr_burst_pkg::*;
#(
  parameter int            DW      = 32,
  parameter int            AW      = 8,
  parameter int            NUM_EVT = 4,
  parameter logic [AW-1:0] CFG_OFF = 8'h48,
  parameter logic [AW-1:0] BUF_OFF = 8'h4C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output burst_cfg_t         cfg_o,
  output logic [NUM_EVT-1:0] mask_o,
  output logic               buf_wr_o,
  output logic [DW-1:0]      buf_data_o
);
  logic cfg_wr;

  assign cfg_wr     = bus_we_i && (bus_addr_i == CFG_OFF);
  assign buf_wr_o   = bus_we_i && (bus_addr_i == BUF_OFF);
  assign buf_data_o = bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      mask_o <= '0;
    end else if (cfg_wr) begin
      cfg_o.start <= bus_wdata_i[START_LSB +: IDX_W];
      cfg_o.count <= bus_wdata_i[CNT_LSB +: CNT_W];
      mask_o      <= bus_wdata_i[MASK_LSB +: NUM_EVT];
    end
  end
endmodule

// File: rtl/tbd_evt_sel.sv
module tbd_evt_sel #(
  parameter int NUM_EVT = 4
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] mask_i,
  output logic               hit_o
);
  logic [NUM_EVT-1:0] gated;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_gate
    assign gated[k] = evt_i[k] & mask_i[k];
  end

  assign hit_o = |gated;
endmodule

// File: rtl/tbd_burst_seq.sv
module tbd_burst_seq
  import tmr_burst_pkg::*;
#(
  parameter int NUM_REGS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  burst_cfg_t       cfg_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] rem_q;
  logic             err_q;
  logic             xfer;

  assign xfer   = (state_q == ST_REQ) && ack_i;
  assign req_o  = (state_q == ST_REQ);
  assign busy_o = (state_q != ST_IDLE);
  assign err_o  = err_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hit_i) begin
            if (cfg_i.start > LAST_IDX) begin
              err_q <= 1'b1;
            end else begin
              err_q   <= 1'b0;
              idx_q   <= cfg_i.start;
              rem_q   <= cfg_i.count;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (xfer) begin
            if (rem_q == '0) begin
              state_q <= ST_IDLE;
            end else if (idx_q == LAST_IDX) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              rem_q   <= rem_q - 1'b1;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP:  state_q <= ST_REQ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbd_rf_steer.sv
module tbd_rf_steer
  import tmr_burst_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NUM_REGS = 20
) (
  input  logic             busy_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] start_i,
  input  logic             buf_wr_i,
  input  logic [DW-1:0]    buf_data_i,
  output logic             rf_we_o,
  output logic [IDX_W+1:0] rf_addr_o,
  output logic [DW-1:0]    rf_wdata_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] tgt;

  // idle writes land at the configured start register
  assign tgt        = busy_i ? idx_i : start_i;
  assign rf_we_o    = buf_wr_i && (tgt <= LAST_IDX);
  assign rf_addr_o  = {tgt, 2'b00};
  assign rf_wdata_o = buf_data_i;
endmodule

// File: rtl/tmr_burst_dma.sv
module tmr_burst_dma
  import tmr_burst_pkg::*;
#(
  parameter int            NUM_EVT  = 4,
  parameter int            NUM_REGS = 20,
  parameter int            DW       = 32,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CFG_OFF  = 8'h48,
  parameter logic [AW-1:0] BUF_OFF  = 8'h4C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic               dma_req_o,
  input  logic               dma_ack_i,
  output logic               rf_we_o,
  output logic [IDX_W+1:0]   rf_addr_o,
  output logic [DW-1:0]      rf_wdata_o,
  output logic               busy_o,
  output logic               err_o
);
  burst_cfg_t         cfg;
  logic [NUM_EVT-1:0] mask;
  logic               buf_wr;
  logic [DW-1:0]      buf_data;
  logic               hit;
  logic [IDX_W-1:0]   idx;

  tbd_cfg_reg #(
    .DW(DW), .AW(AW), .NUM_EVT(NUM_EVT), .CFG_OFF(CFG_OFF), .BUF_OFF(BUF_OFF)
  ) u_cfg (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .cfg_o(cfg), .mask_o(mask), .buf_wr_o(buf_wr), .buf_data_o(buf_data)
  );

  tbd_evt_sel #(.NUM_EVT(NUM_EVT)) u_evt (
    .evt_i, .mask_i(mask), .hit_o(hit)
  );

  tbd_burst_seq #(.NUM_REGS(NUM_REGS)) u_seq (
    .clk_i, .rst_ni, .hit_i(hit), .cfg_i(cfg), .ack_i(dma_ack_i),
    .req_o(dma_req_o), .busy_o(busy_o), .err_o(err_o), .idx_o(idx)
  );

  tbd_rf_steer #(.DW(DW), .NUM_REGS(NUM_REGS)) u_steer (
    .busy_i(busy_o), .idx_i(idx), .start_i(cfg.start),
    .buf_wr_i(buf_wr), .buf_data_i(buf_data),
    .rf_we_o, .rf_addr_o, .rf_wdata_o
  );
endmodule

// File: rtl/tmr_burst_dma_chk.sv
module tmr_burst_dma_chk #(
  parameter int NUM_REGS = 20,
  parameter int RA_W     = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dma_req_o,
  input logic            dma_ack_i,
  input logic            rf_we_o,
  input logic [RA_W-1:0] rf_addr_o,
  input logic            busy_o,
  input logic            err_o
);
  localparam logic [RA_W-1:0] LAST_ADDR = RA_W'((NUM_REGS - 1) * 4);

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> busy_o); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dma_ack_i) |=> !dma_req_o); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dma_req_o && dma_ack_i) |=> (!busy_o || rf_addr_o == $past(rf_addr_o) + RA_W'(4))); // R5
  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_addr_o <= LAST_ADDR)); // R8
  AST_ERR_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(dma_req_o && dma_ack_i)) |=> busy_o); // R6
  AST_START_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> dma_req_o); // R3
endmodule

bind tmr_burst_dma tmr_burst_dma_chk #(.NUM_REGS(NUM_REGS), .RA_W(tmr_burst_pkg::IDX_W + 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_req_o(dma_req_o), .dma_ack_i(dma_ack_i),
  .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/tmr_burst_dma_tb.sv
`timescale 1ns/1ps
module tmr_burst_dma_tb;
  localparam logic [7:0] CFG_A = 8'h48;
  localparam logic [7:0] BUF_A = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  evt_i = '0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        dma_req_o, dma_ack_i = 1'b0;
  logic        rf_we_o;
  logic [6:0]  rf_addr_o;
  logic [31:0] rf_wdata_o;
  logic        busy_o, err_o;

  int n_chk = 0, n_fail = 0, log_n = 0;
  int log_a [64];
  logic [31:0] log_d [64];

  always #2.5 clk = ~clk;

  tmr_burst_dma u_dut (
    .clk_i(clk), .rst_ni, .evt_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .dma_req_o, .dma_ack_i, .rf_we_o, .rf_addr_o, .rf_wdata_o, .busy_o, .err_o
  );

  always @(posedge clk) if (rf_we_o && log_n < 64) begin
    log_a[log_n] = int'(rf_addr_o);
    log_d[log_n] = rf_wdata_o;
    log_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int start, input int cnt, input int mask);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = CFG_A;
    bus_wdata_i = 32'(start) | (32'(cnt) << 8) | (32'(mask) << 16);
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic fire(input int e);
    @(negedge clk);
    evt_i = 4'(1 << e);
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic buf_write(input logic [31:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = BUF_A; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  // DMA model: wait for request, delay, write buffer with acknowledge
  task automatic serve(input int dly, input logic [31:0] d);
    int g = 0;
    while (!dma_req_o && g < 200) begin @(negedge clk); g++; end
    chk(dma_req_o, "R4 request raised", int'(dma_req_o), 1);
    repeat (dly) @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = BUF_A; bus_wdata_i = d; dma_ack_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0; dma_ack_i = 1'b0;
    chk(!dma_req_o, "R4 request low after ack", int'(dma_req_o), 0);
  endtask

  task automatic chk_log(input int base, input int n, input int addr0, input logic [31:0] d0,
                         input string tag);
    chk(log_n == base + n, {tag, " write count"}, log_n - base, n);
    for (int i = 0; i < n; i++) begin
      chk(log_a[base+i] == addr0 + 4*i, {tag, " address"}, log_a[base+i], addr0 + 4*i);
      chk(log_d[base+i] == d0 + 32'(i), {tag, " data"}, int'(log_d[base+i]), int'(d0) + i);
    end
  endtask

  task automatic t_reset;
    chk(!dma_req_o && !busy_o && !err_o && !rf_we_o, "R10 reset outputs",
        {dma_req_o, busy_o, err_o, rf_we_o}, 0);
    fire(0);
    chk(!busy_o, "R10 no event enabled after reset", int'(busy_o), 0);
  endtask

  task automatic t_basic;
    int b = log_n;
    cfg_write(2, 3, 1);
    fire(0);
    chk(busy_o && dma_req_o, "R3 start", {busy_o, dma_req_o}, 3);
    for (int i = 0; i < 4; i++) begin
      serve(i % 2, 32'hA000_0000 + 32'(i));
      if (i < 3) begin
        chk(busy_o, "R7 busy mid burst", int'(busy_o), 1);
        @(negedge clk);
        chk(dma_req_o, "R4 request back after gap", int'(dma_req_o), 1);
      end
    end
    chk(!busy_o, "R7 idle after last", int'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk(!dma_req_o, "R2 no extra request", int'(dma_req_o), 0);
    chk_log(b, 4, 8, 32'hA000_0000, "R2 R5 R1 basic");
  endtask

  task automatic t_single;
    int b = log_n;
    cfg_write(5, 0, 2);
    fire(1);
    serve(3, 32'hB000_0000);
    chk(!busy_o, "R2 single transfer done", int'(busy_o), 0);
    chk_log(b, 1, 20, 32'hB000_0000, "R2 count zero");
  endtask

  task automatic t_masked;
    cfg_write(0, 1, 1);
    fire(2);
    chk(!busy_o && !dma_req_o, "R3 masked event", {busy_o, dma_req_o}, 0);
  endtask

  task automatic t_ignore;
    int b = log_n;
    cfg_write(0, 1, 1);
    fire(0);
    fire(0);
    serve(0, 32'hC000_0000);
    fire(0);
    serve(2, 32'hC000_0001);
    chk(!busy_o, "R6 burst ends on schedule", int'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk(!dma_req_o && !busy_o, "R6 no restart", {dma_req_o, busy_o}, 0);
    chk_log(b, 2, 0, 32'hC000_0000, "R6 ignore");
  endtask

  task automatic t_overrun;
    int b = log_n;
    cfg_write(18, 3, 1);
    fire(0);
    serve(0, 32'hD000_0000);
    serve(1, 32'hD000_0001);
    chk(!busy_o && err_o, "R8 stop at last register", {busy_o, err_o}, 1);
    repeat (3) @(negedge clk);
    chk(!dma_req_o, "R8 no request after stop", int'(dma_req_o), 0);
    chk_log(b, 2, 72, 32'hD000_0000, "R8 overrun");
    cfg_write(20, 0, 1);
    fire(0);
    chk(!busy_o && !dma_req_o && err_o, "R8 start out of range", {busy_o, dma_req_o, err_o}, 1);
    buf_write(32'hDEAD_0000);
    chk(log_n == b + 2, "R8 idle write out of range dropped", log_n - b, 2);
    cfg_write(0, 0, 1);
    fire(0);
    chk(busy_o && !err_o, "R8 error cleared on new burst", {busy_o, err_o}, 2);
    serve(0, 32'hD100_0000);
  endtask

  task automatic t_midcfg;
    int b = log_n;
    cfg_write(4, 2, 1);
    fire(0);
    serve(0, 32'hE000_0000);
    cfg_write(10, 0, 1);
    serve(0, 32'hE000_0001);
    serve(1, 32'hE000_0002);
    chk(!busy_o, "R9 burst length kept", int'(busy_o), 0);
    chk_log(b, 3, 16, 32'hE000_0000, "R9 captured config");
  endtask

  task automatic t_idle_write;
    int b = log_n;
    cfg_write(7, 0, 0);
    buf_write(32'hF000_0000);
    chk(!busy_o, "R1 idle write does not start burst", int'(busy_o), 0);
    chk_log(b, 1, 28, 32'hF000_0000, "R1 idle steering");
  endtask

  task automatic t_repeat;
    int b = log_n;
    cfg_write(1, 1, 8);
    for (int r = 0; r < 2; r++) begin
      fire(3);
      serve(0, 32'h1000_0000);
      serve(2, 32'h1000_0001);
      chk(!busy_o, "R11 burst complete", int'(busy_o), 0);
      chk_log(b + 2*r, 2, 4, 32'h1000_0000, "R11 repeat");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_masked();
    t_ignore();
    t_overrun();
    t_midcfg();
    t_idle_write();
    t_repeat();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule